// File: doc/BRIEF.md
# Banked Memory Map Controller

This block turns a 16-bit processor address into a device select and a wider physical address. The 64 KB space is split into four 16 KB regions. The lowest region holds ROM or RAM. The second region is always fixed RAM. The upper 32 KB is a paged window. Three registers, written through a small I/O port, set up the map: two page registers and one configuration register. The configuration register can be read back. The page registers are write-only.

The upper window works in one of two modes. In the normal mode it is a single 32 KB page chosen by the low page register. In the extended mode it is two separate 16 KB pages, one chosen by each page register. A configuration bit takes ROM out of the map, so that RAM fills the whole space. Another bit blocks writes to the first 32 KB of physical RAM. The selects and the write gate are combinational from the CPU strobes and the stored registers. Register writes are captured on the clock edge.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset all three registers read as zero. This gives ROM mode, no write protection and normal paging. A read of 0x0123 selects ROM at physical address 0x0123, and a configuration read returns 0x00.
- R2: CPU addresses 0x4000-0x7FFF always select RAM at the physical address equal to the CPU address (the fixed 16 KB page 1), whatever the configuration.
- R3: With configuration bit 0 = 0, every CPU address outside 0x4000-0x7FFF selects ROM. Addresses 0x0000-0x3FFF map to ROM physical address 0x0000-0x3FFF.
- R4: With configuration bit 0 = 1, every CPU address selects RAM. Addresses 0x0000-0x3FFF map to physical 0x0000-0x3FFF.
- R5: With configuration bit 3 = 0, CPU addresses 0x8000-0xFFFF map to physical address lowPage*0x8000 + (addr mod 0x8000).
- R6: With configuration bit 3 = 1, 0x8000-0xBFFF maps to lowPage*0x4000 + (addr mod 0x4000), and 0xC000-0xFFFF maps to highPage*0x4000 + (addr mod 0x4000).
- R7: With configuration bit 1 = 1, a RAM write whose physical address is below 0x8000 leaves the write enable low. Every other RAM write raises it.
- R8: A write cycle that selects ROM never raises the write enable.
- R9: A read at I/O address 0x2A returns all eight bits last written there, including the bits with no effect on the map. Reads at the page register addresses (0x20 low, 0x21 high) or with no read strobe return 0x00.
- R10: A register write is captured on the clock edge that ends its strobe cycle. The map keeps its old setting during that cycle and uses the new one from the next cycle.
- R11: With neither memory strobe active, the ROM select, RAM select and write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor address |
| memRd | input | 1 | Memory read strobe |
| memWr | input | 1 | Memory write strobe |
| ioAddr | input | 8 | I/O register address |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data (configuration register or zero) |
| romSel | output | 1 | ROM device select |
| ramSel | output | 1 | RAM device select |
| physAddr | output | PAGE_W+15 (23) | Extended physical address |
| wrEn | output | 1 | Gated RAM write enable |

## Verification
The selects, the physical address, the write gate and the read data change in the same cycle as the CPU address or strobe that causes them. A register write changes the map one clock edge later. The driver sets each stimulus on the falling edge and queues the expected result for that cycle. The monitor compares it one nanosecond later, so a register write is seen with the old map in its own cycle and with the new map on the next entry.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  // Positions of the configuration bits that steer the map
  localparam int CFG_NOROM_BIT = 0;
  localparam int CFG_WPROT_BIT = 1;
  localparam int CFG_EXT_BIT   = 3;
  localparam int CFG_W         = 8;

  // Region split of the 64 KB CPU space
  localparam int CPU_ADDR_W = 16;
  localparam int OFFSET_W   = 14;

  typedef struct packed {
    logic wrPageLo;
    logic wrPageHi;
    logic wrCfg;
    logic rdCfg;
  } regStrobe_t;

endpackage

// File: rtl/bank_map_decode.sv
module bank_map_decode
  import bank_map_pkg::*;
#(
  parameter int IO_ADDR_W = 8,
  parameter logic [IO_ADDR_W-1:0] ADDR_PAGE_LO = 8'h20,
  parameter logic [IO_ADDR_W-1:0] ADDR_PAGE_HI = 8'h21,
  parameter logic [IO_ADDR_W-1:0] ADDR_CFG     = 8'h2A
) (
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic                 ioWr,
  input  logic                 ioRd,
  output regStrobe_t           strb
);

  always_comb begin
    strb          = '0;
    strb.wrPageLo = ioWr && (ioAddr == ADDR_PAGE_LO);
    strb.wrPageHi = ioWr && (ioAddr == ADDR_PAGE_HI);
    strb.wrCfg    = ioWr && (ioAddr == ADDR_CFG);
    strb.rdCfg    = ioRd && (ioAddr == ADDR_CFG);
  end

endmodule

// File: rtl/bank_map_path.sv
module bank_map_path
  import bank_map_pkg::*;
#(
  parameter int PAGE_W = 8,
  localparam int PHYS_W = PAGE_W + OFFSET_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [CFG_W-1:0]      ioWrData,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic                  memRd,
  input  logic                  memWr,
  output logic [CFG_W-1:0]      ioRdData,
  output logic                  romSel,
  output logic                  ramSel,
  output logic [PHYS_W-1:0]     physAddr,
  output logic                  wrEn
);

  logic [CFG_W-1:0]  cfgQ;
  logic [PAGE_W-1:0] pageLoQ;
  logic [PAGE_W-1:0] pageHiQ;

  // Register file: captured on the edge that ends the strobe cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ    <= '0;
      pageLoQ <= '0;
      pageHiQ <= '0;
    end else begin
      if (strb.wrCfg)    cfgQ    <= ioWrData;
      if (strb.wrPageLo) pageLoQ <= ioWrData[PAGE_W-1:0];
      if (strb.wrPageHi) pageHiQ <= ioWrData[PAGE_W-1:0];
    end
  end

  logic [1:0]        region;
  logic              access;
  logic              noRom;
  logic              wProt;
  logic              extMode;
  logic              toRom;
  logic [PAGE_W-1:0] smallPage;
  logic              lowRam;

  assign region    = cpuAddr[CPU_ADDR_W-1 -: 2];
  assign access    = memRd || memWr;
  assign noRom     = cfgQ[CFG_NOROM_BIT];
  assign wProt     = cfgQ[CFG_WPROT_BIT];
  assign extMode   = cfgQ[CFG_EXT_BIT];
  assign toRom     = !noRom && (region != 2'd1);
  assign smallPage = region[0] ? pageHiQ : pageLoQ;

  always_comb begin
    unique case (region)
      2'd0:    physAddr = PHYS_W'(cpuAddr[OFFSET_W-1:0]);
      2'd1:    physAddr = PHYS_W'({1'b1, cpuAddr[OFFSET_W-1:0]});
      default: begin
        if (extMode) physAddr = PHYS_W'({smallPage, cpuAddr[OFFSET_W-1:0]});
        else         physAddr = {pageLoQ, cpuAddr[OFFSET_W:0]};
      end
    endcase
  end

  assign lowRam   = (physAddr[PHYS_W-1:OFFSET_W+1] == '0);
  assign romSel   = access && toRom;
  assign ramSel   = access && !toRom;
  assign wrEn     = memWr && !toRom && !(wProt && lowRam);
  assign ioRdData = strb.rdCfg ? cfgQ : '0;

  // R8: never both devices, and never a write gate toward ROM
  a_r8_rom_no_write: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> (!ramSel && !wrEn));

  // R11: nothing selected without a memory strobe
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd || memWr) |-> (!romSel && !ramSel && !wrEn));

  // R2: fixed RAM region follows the CPU address exactly
  a_r2_fixed_ram: assert property (@(posedge clk) disable iff (!rstN)
    ((memRd || memWr) && cpuAddr[15:14] == 2'b01) |->
      (ramSel && physAddr == PHYS_W'(cpuAddr)));

  // R7: protected low RAM never sees a write gate
  a_r7_low_protected: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[CFG_WPROT_BIT] && physAddr < PHYS_W'(32'h8000)) |-> !wrEn);

  // R9 / R10: configuration takes the written byte one edge later and holds otherwise
  a_r9_cfg_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCfg |=> (cfgQ == $past(ioWrData)));

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCfg |=> $stable(cfgQ));

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
  import bank_map_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int IO_ADDR_W = 8,
  parameter logic [IO_ADDR_W-1:0] ADDR_PAGE_LO = 8'h20,
  parameter logic [IO_ADDR_W-1:0] ADDR_PAGE_HI = 8'h21,
  parameter logic [IO_ADDR_W-1:0] ADDR_CFG     = 8'h2A,
  localparam int PHYS_W = PAGE_W + OFFSET_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic                  memRd,
  input  logic                  memWr,
  input  logic [IO_ADDR_W-1:0]  ioAddr,
  input  logic                  ioWr,
  input  logic                  ioRd,
  input  logic [CFG_W-1:0]      ioWrData,
  output logic [CFG_W-1:0]      ioRdData,
  output logic                  romSel,
  output logic                  ramSel,
  output logic [PHYS_W-1:0]     physAddr,
  output logic                  wrEn
);

  regStrobe_t strb;

  bank_map_decode #(
    .IO_ADDR_W   (IO_ADDR_W),
    .ADDR_PAGE_LO(ADDR_PAGE_LO),
    .ADDR_PAGE_HI(ADDR_PAGE_HI),
    .ADDR_CFG    (ADDR_CFG)
  ) u_decode (
    .ioAddr(ioAddr),
    .ioWr  (ioWr),
    .ioRd  (ioRd),
    .strb  (strb)
  );

  bank_map_path #(
    .PAGE_W(PAGE_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .ioWrData(ioWrData),
    .cpuAddr (cpuAddr),
    .memRd   (memRd),
    .memWr   (memWr),
    .ioRdData(ioRdData),
    .romSel  (romSel),
    .ramSel  (ramSel),
    .physAddr(physAddr),
    .wrEn    (wrEn)
  );

endmodule

// File: tb/bank_map_ctrl_tb.sv
`timescale 1ns/1ps
module bank_map_ctrl_tb;

  localparam logic [7:0] A_LO  = 8'h20;
  localparam logic [7:0] A_HI  = 8'h21;
  localparam logic [7:0] A_CFG = 8'h2A;

  typedef struct packed {
    logic        rom;
    logic        ram;
    logic [22:0] phys;
    logic        wr;
    logic [7:0]  rd;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        memRd = 1'b0, memWr = 1'b0;
  logic [7:0]  ioAddr = '0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        romSel, ramSel, wrEn;
  logic [22:0] physAddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  expT   qExp[$];
  string qTag[$];

  logic [7:0] sCfg = '0, sLo = '0, sHi = '0;

  always #2 clk = ~clk;

  bank_map_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .memRd(memRd), .memWr(memWr),
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .romSel(romSel), .ramSel(ramSel),
    .physAddr(physAddr), .wrEn(wrEn)
  );

  // Reference model written from the requirements
  function automatic expT model(input logic [15:0] a, input logic rd, input logic wr,
                                input logic [7:0] ia, input logic ir);
    expT e;
    int unsigned off14, off15, phys;
    logic access, toRom;
    off14  = int'(a) % 16384;
    off15  = int'(a) % 32768;
    access = rd || wr;
    toRom  = !sCfg[0] && (a < 16'h4000 || a >= 16'h8000);
    if (a < 16'h4000)      phys = off14;
    else if (a < 16'h8000) phys = 16384 + off14;
    else if (sCfg[3])      phys = ((a < 16'hC000) ? int'(sLo) : int'(sHi)) * 16384 + off14;
    else                   phys = int'(sLo) * 32768 + off15;
    e.rom  = access && toRom;
    e.ram  = access && !toRom;
    e.phys = phys[22:0];
    e.wr   = wr && !toRom && !(sCfg[1] && phys < 32768);
    e.rd   = (ir && ia == A_CFG) ? sCfg : 8'h00;
    return e;
  endfunction

  // Driver: one stimulus per cycle, expectation queued for that cycle
  task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                      input logic [7:0] ia, input logic iw, input logic ir,
                      input logic [7:0] d, input string tag);
    @(negedge clk);
    cpuAddr = a; memRd = rd; memWr = wr;
    ioAddr = ia; ioWr = iw; ioRd = ir; ioWrData = d;
    qExp.push_back(model(a, rd, wr, ia, ir));
    qTag.push_back(tag);
    if (iw) begin
      if (ia == A_CFG) sCfg = d;
      if (ia == A_LO)  sLo  = d;
      if (ia == A_HI)  sHi  = d;
    end
  endtask

  task automatic rdMem(input logic [15:0] a, input string tag);
    step(a, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic wrMem(input logic [15:0] a, input string tag);
    step(a, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, tag);
  endtask

  task automatic ioWrite(input logic [7:0] ia, input logic [7:0] d,
                         input logic [15:0] a, input string tag);
    step(a, 1'b1, 1'b0, ia, 1'b1, 1'b0, d, tag);
  endtask

  task automatic ioRead(input logic [7:0] ia, input string tag);
    step(16'h0000, 1'b0, 1'b0, ia, 1'b0, 1'b1, 8'h00, tag);
  endtask

  // Monitor: compares each queued expectation away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (qExp.size() > 0) begin
        expT e;
        string t;
        e = qExp.pop_front();
        t = qTag.pop_front();
        checks++;
        if (romSel !== e.rom || ramSel !== e.ram || physAddr !== e.phys ||
            wrEn !== e.wr || ioRdData !== e.rd) begin
          failures++;
          $display("FAIL %s: got rom=%0b ram=%0b phys=%h wr=%0b rd=%h expected rom=%0b ram=%0b phys=%h wr=%0b rd=%h",
                   t, romSel, ramSel, physAddr, wrEn, ioRdData,
                   e.rom, e.ram, e.phys, e.wr, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R10: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    ioRead(A_CFG, "R1 cfg after reset");
    rdMem(16'h0123, "R1 rom at reset");
    // R11 idle
    step(16'h9000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R11 no strobe");
    // R3 rom regions
    rdMem(16'h3FFF, "R3 low rom top");
    rdMem(16'h9234, "R3 upper window rom page 0");
    // R8 write toward rom
    wrMem(16'h0010, "R8 write to rom");
    // R2 fixed ram
    rdMem(16'h5ABC, "R2 fixed ram read");
    wrMem(16'h4000, "R2 fixed ram write");

    // R10: low page write, old map in its own cycle
    ioWrite(A_LO, 8'h05, 16'hC001, "R10 old page during write");
    rdMem(16'hC001, "R5 normal page 5");
    rdMem(16'h8000, "R5 normal page 5 base");

    // R4 rom removed
    ioWrite(A_CFG, 8'h01, 16'h1234, "R10 still rom during cfg write");
    rdMem(16'h1234, "R4 ram at low region");
    wrMem(16'h1234, "R4 ram write open");
    wrMem(16'hFFFF, "R4 ram upper window");

    // R7 write protection
    ioWrite(A_CFG, 8'h03, 16'h0000, "R7 cfg write");
    wrMem(16'h1234, "R7 low ram blocked");
    wrMem(16'h7FFF, "R7 fixed ram blocked");
    wrMem(16'hC000, "R7 page 5 open");
    ioWrite(A_LO, 8'h00, 16'h0000, "R7 page write");
    wrMem(16'h8000, "R7 upper page 0 blocked");
    ioWrite(A_LO, 8'h01, 16'h0000, "R7 page write");
    wrMem(16'h8000, "R7 boundary 0x8000 open");

    // R6 extended paging
    ioWrite(A_CFG, 8'h0B, 16'h0000, "R6 cfg write");
    ioWrite(A_LO, 8'h12, 16'h0000, "R6 low page write");
    ioWrite(A_HI, 8'hFF, 16'h0000, "R6 high page write");
    rdMem(16'h8005, "R6 low small window");
    rdMem(16'hFFFF, "R6 high small window top");
    rdMem(16'hBFFF, "R6 low small window top");
    ioWrite(A_HI, 8'h01, 16'h0000, "R6 high page write");
    wrMem(16'hC010, "R6 R7 small page 1 blocked");
    ioWrite(A_HI, 8'h02, 16'h0000, "R6 high page write");
    wrMem(16'hC010, "R6 small page 2 open");

    // R9 read back
    ioWrite(A_CFG, 8'hF4, 16'h0000, "R9 cfg write");
    ioRead(A_CFG, "R9 cfg readback F4");
    ioRead(A_LO, "R9 page reg reads zero");
    ioRead(A_HI, "R9 page reg reads zero");
    rdMem(16'h0200, "R3 rom back with bit0 clear");
    wrMem(16'h9000, "R8 paged rom write");
    ioWrite(A_CFG, 8'hA5, 16'h0000, "R9 cfg write");
    ioRead(A_CFG, "R9 cfg readback A5");
    step(16'h0000, 1'b0, 1'b0, A_CFG, 1'b0, 1'b0, 8'h00, "R9 no read strobe");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule